// File: doc/BRIEF.md
# Seamless Frame-Change Readout Controller

This block paces the readout of a pixel array split into two halves that share a data bus. It issues one readout-control pulse per packet slot, alternating between the top and bottom halves. While one half's packet is being serialized, the other half is enabled and settles its next word onto the bus. A pulse's rising edge takes the current pixel off the bus. Its falling edge hands the bus to the next pixel in priority order.

The frame period is set by a slow frame clock that has no fixed phase relation to the bit clock. When a rising frame edge arrives, the controller does the following in order:
- It lets the packet in flight finish.
- It holds both halves disabled by keeping their control pulses high.
- It releases a frame strobe to the array for a programmable number of bit clocks, so the new priority list can form everywhere.
- It asks the serializer for a two-packet boundary marker. In imaging mode this is a known header; in sparse mode the last packet is sent again.
- It drops both pulses to enable the highest-priority pixels, then resumes readout.

A frame edge that arrives while a change is already under way is remembered and served right after.

Top module: `rfc_frame_ctrl`

## Requirements
- R1: While reset is asserted, the controller sits at bit 0 of a top-half packet: `roc_top`=1, `roc_bot`=0, `pkt_start`=1, and `frame_clk_arr`, `send_marker` and `send_repeat` are 0.
- R2: In normal readout, packets are `PKT_BITS` cycles long and alternate top, bottom, starting with top. The half owning a packet has its control output high for bit positions 0 to `PULSE_W`-1, and the other half's output is low. `pkt_start` is high exactly at bit 0.
- R3: A rising `frame_clk_in` that is stable before bit-clock edge k starts the finishing phase at edge k+2. Normal outputs continue until the first packet whose last bit falls at or after edge k+2 completes. The disabled window begins in the very next cycle.
- R4: The disabled window opens with one cycle in which both control outputs are high and `frame_clk_arr` is low. Then follow `hold_len` cycles with both control outputs and `frame_clk_arr` high.
- R5: A `hold_len` of 0 gives a strobe of exactly one cycle.
- R6: After the strobe, both control outputs stay high for 2×`PKT_BITS` cycles. During these cycles `send_marker` is high if `frame_mode`=0 (imaging) or `send_repeat` is high if `frame_mode`=1 (sparse), and `frame_clk_arr` is low.
- R7: `frame_mode` is sampled in the last cycle of the finished packet. Changing it later has no effect on the marker type of that change.
- R8: After the marker, both control outputs are low for `SETTLE_CYC` cycles. Readout then restarts at bit 0 of a top packet.
- R9: A rising frame edge seen between the finishing phase and the end of the settle cycles is held. It starts a new finishing phase straight after the settle cycles. That phase completes one full packet before the next disabled window.
- R10: A falling edge of `frame_clk_in`, or a level held high, starts no frame change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| frame_clk_in | input | 1 | Asynchronous frame clock; its rising edge requests a frame change |
| frame_mode | input | 1 | 0 = imaging (known header), 1 = sparse (repeat last packet) |
| hold_len | input | HOLD_W | Bit clocks the frame strobe stays high (0 treated as 1) |
| roc_top | output | 1 | Readout-control pulse for the top half |
| roc_bot | output | 1 | Readout-control pulse for the bottom half |
| frame_clk_arr | output | 1 | Frame strobe released to the pixel array |
| send_marker | output | 1 | Serializer sends the known header |
| send_repeat | output | 1 | Serializer resends the last packet |
| pkt_start | output | 1 | First bit of a readout packet |

## Verification
The block reaches a new frame in a fixed number of bit clocks. The synchronizer delays the request by three edges after the input rises. From there, completing the packet takes up to `PKT_BITS` cycles, the disable cycle takes one, the strobe takes `hold_len` (at least one), the marker takes twice `PKT_BITS`, and settling takes `SETTLE_CYC`. A driver raises the frame input at a known sample, computes each segment boundary from these counts, and queues one expected output word per sample index. A monitor pops each word at the falling clock edge of exactly that sample, so every output is judged in the cycle it is due. The edge is placed at several packet phases, including the two where the packet boundary lands one or zero cycles after the request.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_FINISH,
    ST_DISABLE,
    ST_PROPAGATE,
    ST_MARKER,
    ST_ENABLE
  } chg_state_t;

  // strobe length in bit clocks; zero is promoted to one
  function automatic int eff_hold(input int h);
    return (h == 0) ? 1 : h;
  endfunction

  // boundary marker spans two packets
  function automatic int marker_cycles(input int pkt_bits);
    return 2 * pkt_bits;
  endfunction

  // control pulse is high for the first w bits of the owning packet
  function automatic logic pulse_on(input int pos, input int w);
    return pos < w;
  endfunction

endpackage

// File: rtl/rfc_edge_sync.sv
module rfc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q && !s3_q;

  // R10
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/rfc_pkt_timer.sv
module rfc_pkt_timer #(
  parameter int PKT_BITS = 20,
  localparam int POS_W = $clog2(PKT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  output logic [POS_W-1:0] pos_o,
  output logic             half_o,
  output logic             last_o
);
  logic [POS_W-1:0] pos_q;
  logic             half_q;

  assign last_o = (pos_q == POS_W'(PKT_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      half_q <= 1'b0;
    end else if (restart) begin
      pos_q  <= '0;
      half_q <= 1'b0;
    end else if (run) begin
      if (last_o) begin
        pos_q  <= '0;
        half_q <= !half_q;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign pos_o  = pos_q;
  assign half_o = half_q;

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_W'(PKT_BITS - 1));

  // R2
  half_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && last_o) |=> (half_q != $past(half_q)));

endmodule

// File: rtl/rfc_change_fsm.sv
module rfc_change_fsm
  import rfc_pkg::*;
#(
  parameter int PKT_BITS   = 20,
  parameter int HOLD_W     = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_rise,
  input  logic              last_bit,
  input  logic [HOLD_W-1:0] hold_len,
  input  logic              frame_mode,
  output chg_state_t        state_o,
  output logic              mode_q_o,
  output logic              restart_o,
  output logic              live_o
);
  localparam int MRK      = marker_cycles(PKT_BITS);
  localparam int HOLD_MAX = 1 << HOLD_W;
  localparam int CMAX_A   = (HOLD_MAX > MRK) ? HOLD_MAX : MRK;
  localparam int CMAX     = (CMAX_A > SETTLE_CYC) ? CMAX_A : SETTLE_CYC;
  localparam int CNT_W    = $clog2(CMAX + 1);

  chg_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             mode_q, mode_d;
  logic [CNT_W-1:0] hold_last;
  logic             prop_done, mrk_done, settle_done;

  assign hold_last   = CNT_W'(eff_hold(int'(hold_len)) - 1);
  assign prop_done   = (cnt_q == hold_last);
  assign mrk_done    = (cnt_q == CNT_W'(MRK - 1));
  assign settle_done = (cnt_q == CNT_W'(SETTLE_CYC - 1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    pend_d = pend_q || (frame_rise && (st_q != ST_RUN));
    case (st_q)
      ST_RUN: begin
        if (frame_rise) st_d = ST_FINISH;
      end
      ST_FINISH: begin
        if (last_bit) begin
          st_d   = ST_DISABLE;
          mode_d = frame_mode;
        end
      end
      ST_DISABLE: begin
        st_d  = ST_PROPAGATE;
        cnt_d = '0;
      end
      ST_PROPAGATE: begin
        if (prop_done) begin
          st_d  = ST_MARKER;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_MARKER: begin
        if (mrk_done) begin
          st_d  = ST_ENABLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ENABLE: begin
        if (settle_done) begin
          st_d   = (pend_q || frame_rise) ? ST_FINISH : ST_RUN;
          pend_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      mode_q <= mode_d;
    end
  end

  assign state_o   = st_q;
  assign mode_q_o  = mode_q;
  assign restart_o = (st_q == ST_MARKER) && mrk_done;
  assign live_o    = (st_q == ST_RUN) || (st_q == ST_FINISH);

  // R3
  finish_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DISABLE) |-> $past(last_bit));

  // R3
  request_enters_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && frame_rise) |=> (st_q == ST_FINISH));

  // R9
  pending_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ENABLE && settle_done && pend_q) |=> (st_q == ST_FINISH));

  // R7
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MARKER && $past(st_q) == ST_MARKER) |-> $stable(mode_q));

endmodule

// File: rtl/rfc_frame_ctrl.sv
module rfc_frame_ctrl
  import rfc_pkg::*;
#(
  parameter int PKT_BITS   = 20,
  parameter int PULSE_W    = 4,
  parameter int SETTLE_CYC = 4,
  parameter int HOLD_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_clk_in,
  input  logic              frame_mode,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              roc_top,
  output logic              roc_bot,
  output logic              frame_clk_arr,
  output logic              send_marker,
  output logic              send_repeat,
  output logic              pkt_start
);
  localparam int POS_W = $clog2(PKT_BITS);

  logic             frame_rise;
  logic [POS_W-1:0] pos;
  logic             half;
  logic             last_bit;
  logic             restart;
  logic             live;
  logic             mode_q;
  chg_state_t       state;
  logic             pulse_now;

  rfc_edge_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (frame_clk_in),
    .rise_o   (frame_rise)
  );

  rfc_pkt_timer #(.PKT_BITS(PKT_BITS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (live),
    .restart (restart),
    .pos_o   (pos),
    .half_o  (half),
    .last_o  (last_bit)
  );

  rfc_change_fsm #(
    .PKT_BITS   (PKT_BITS),
    .HOLD_W     (HOLD_W),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_rise (frame_rise),
    .last_bit   (last_bit),
    .hold_len   (hold_len),
    .frame_mode (frame_mode),
    .state_o    (state),
    .mode_q_o   (mode_q),
    .restart_o  (restart),
    .live_o     (live)
  );

  assign pulse_now = pulse_on(int'(pos), PULSE_W);

  always_comb begin
    roc_top       = 1'b0;
    roc_bot       = 1'b0;
    frame_clk_arr = 1'b0;
    send_marker   = 1'b0;
    send_repeat   = 1'b0;
    pkt_start     = 1'b0;
    case (state)
      ST_RUN, ST_FINISH: begin
        roc_top   = !half && pulse_now;
        roc_bot   = half && pulse_now;
        pkt_start = (pos == '0);
      end
      ST_DISABLE: begin
        roc_top = 1'b1;
        roc_bot = 1'b1;
      end
      ST_PROPAGATE: begin
        roc_top       = 1'b1;
        roc_bot       = 1'b1;
        frame_clk_arr = 1'b1;
      end
      ST_MARKER: begin
        roc_top     = 1'b1;
        roc_bot     = 1'b1;
        send_marker = !mode_q;
        send_repeat = mode_q;
      end
      default: ;
    endcase
  end

  // R4
  array_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clk_arr |-> (roc_top && roc_bot));

  // R2
  halves_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> $onehot0({roc_top, roc_bot}));

  // R6
  marker_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({send_marker, send_repeat, frame_clk_arr}));

  // R8
  enable_after_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(send_marker || send_repeat) |-> (!roc_top && !roc_bot));

endmodule

// File: tb/rfc_frame_ctrl_test.sv
module rfc_frame_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 20;
  localparam int W  = 4;
  localparam int S  = 4;
  localparam int HW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic frame_clk_in;
  logic frame_mode;
  logic [HW-1:0] hold_len;
  logic roc_top, roc_bot, frame_clk_arr, send_marker, send_repeat, pkt_start;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rfc_frame_ctrl #(.PKT_BITS(P), .PULSE_W(W), .SETTLE_CYC(S), .HOLD_W(HW)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_clk_in  (frame_clk_in),
    .frame_mode    (frame_mode),
    .hold_len      (hold_len),
    .roc_top       (roc_top),
    .roc_bot       (roc_bot),
    .frame_clk_arr (frame_clk_arr),
    .send_marker   (send_marker),
    .send_repeat   (send_repeat),
    .pkt_start     (pkt_start)
  );

  int cyc = 0;
  int total = 0;
  int fails = 0;
  int push_idx = 0;
  int phase = 0;
  bit done_flag = 0;

  int        q_idx[$];
  logic [5:0] q_w[$];
  string     q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [5:0] outs();
    return {roc_top, roc_bot, frame_clk_arr, send_marker, send_repeat, pkt_start};
  endfunction

  task automatic judge(input logic [5:0] got, input logic [5:0] exp, input string tag, input int smp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s sample %0d: got %b expected %b", tag, smp, got, exp);
    end
  endtask

  // monitor: compares each queued word at the falling edge of its sample
  always @(negedge clk) begin
    while (q_idx.size() > 0 && q_idx[0] <= cyc) begin
      judge(outs(), q_w[0], q_tag[0], q_idx[0]);
      void'(q_idx.pop_front());
      void'(q_w.pop_front());
      void'(q_tag.pop_front());
    end
  end

  function automatic logic [5:0] run_word(input int ph);
    int pos = ph % P;
    int hf = (ph / P) % 2;
    return {(hf == 0) && (pos < W), (hf == 1) && (pos < W), 3'b000, pos == 0};
  endfunction

  task automatic push(input logic [5:0] w, input string tag);
    q_idx.push_back(push_idx);
    q_w.push_back(w);
    q_tag.push_back(tag);
    push_idx++;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic sync_push();
    wait_until(push_idx - 1);
  endtask

  task automatic play_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      push(run_word(phase), tag);
      phase++;
    end
    sync_push();
  endtask

  // push until the last pushed sample sits at bit position p
  task automatic play_to(input int p, input string tag);
    do begin
      push(run_word(phase), tag);
      phase++;
    end while (((phase - 1) % P) != p);
    sync_push();
  endtask

  task automatic push_change(input int first, input bit md, input int h,
                             input string ptag, input string mtag,
                             output int ms, output int r);
    bit fin = 0;
    int hh;
    while (!fin) begin
      fin = (push_idx >= first) && ((phase % P) == P - 1);
      push(run_word(phase), ptag);
      phase++;
    end
    push(6'b110000, "R4");
    hh = (h == 0) ? 1 : h;
    for (int i = 0; i < hh; i++) push(6'b111000, (h == 0) ? "R5" : "R4");
    ms = push_idx;
    for (int i = 0; i < 2 * P; i++) push({3'b110, !md, md, 1'b0}, mtag);
    for (int i = 0; i < S; i++) push(6'b000000, "R8");
    r = push_idx;
    phase = 0;
  endtask

  task automatic do_change(input bit md, input int h, input bit flip,
                           input bit second, input bit keep_high);
    int n, ms, r, ms2, r2;
    sync_push();
    n = cyc;
    frame_clk_in = 1'b1;
    frame_mode = md;
    hold_len = HW'(h);
    push_change(n + 3, md, h, "R3", flip ? "R7" : "R6", ms, r);
    if (!keep_high) begin
      wait_until(n + 6);
      frame_clk_in = 1'b0;
    end
    if (flip) begin
      wait_until(ms + 2);
      frame_mode = !md;
    end
    if (second) begin
      wait_until(ms + 1);
      frame_clk_in = 1'b1;
      push_change(r, md, h, "R9", "R9", ms2, r2);
      wait_until(ms + 6);
      frame_clk_in = 1'b0;
    end
    sync_push();
  endtask

  initial begin
    rst_n = 1'b0;
    frame_clk_in = 1'b0;
    frame_mode = 1'b0;
    hold_len = HW'(40);
    repeat (3) @(negedge clk);
    // R1: reset state at bit 0 of a top packet
    judge(outs(), 6'b100001, "R1", cyc);
    rst_n = 1'b1;
    push_idx = cyc + 1;
    phase = 1;
    play_run(30, "R2");
    do_change(1'b0, 40, 1'b0, 1'b0, 1'b0);          // imaging, default hold
    play_run(25, "R2");
    play_to(P - 3, "R2");
    do_change(1'b1, 5, 1'b0, 1'b0, 1'b0);           // R3: boundary just missed
    play_to(P - 4, "R2");
    do_change(1'b0, 2, 1'b0, 1'b0, 1'b0);           // R3: boundary right after request
    play_run(13, "R2");
    do_change(1'b1, 0, 1'b0, 1'b0, 1'b0);           // R5
    play_run(9, "R2");
    do_change(1'b0, 6, 1'b1, 1'b0, 1'b0);           // R7
    play_run(21, "R2");
    do_change(1'b1, 3, 1'b0, 1'b1, 1'b0);           // R9
    play_run(7, "R2");
    do_change(1'b0, 4, 1'b0, 1'b0, 1'b1);           // R10: level stays high
    play_run(50, "R10");
    frame_clk_in = 1'b0;                            // R10: falling edge
    play_run(50, "R10");
    @(negedge clk);
    done_flag = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      total++;
      fails++;
      $display("FAIL watchdog: got no completion, expected end of sequence");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule